// File: doc/BRIEF.md
# CAN Sleep-Mode Bus Activity Detector

This block watches the CAN receive line while the controller sits in its low-power sleep state. When the line moves from recessive (logic 1) to dominant (logic 0) during sleep, the block sets a sticky bus-activity flag. It also raises an interrupt request when interrupts are enabled. When automatic wake-up is enabled, the same event produces a one-cycle wake request that the mode controller uses to leave sleep.

The raw receive line first passes through a synchroniser chain. The falling edge is found by comparing each synchronised sample with the one before it. Software clears the flag with a write-one-to-clear access. A single write-data bit carries the value written to the flag position. The bit-timing engine, the protocol state machine and clock gating sit outside this block.

Top module: `can_sleep_wake`

## Requirements
- R1: With the default two synchroniser stages, a 1→0 change on `rx_i` while `sleep_i` is 1 sets `flag_o`. The flag is visible after the third rising clock edge that follows the change.
- R2: After reset, `flag_o`, `irq_o` and `wake_req_o` are all 0.
- R3: A 0→1 change on `rx_i`, or a line held at either level, never sets `flag_o`.
- R4: A 1→0 change on `rx_i` that reaches the edge detector while `sleep_i` is 0 never sets `flag_o`.
- R5: A write with `wr_en_i`=1 and `wr_bit_i`=1 clears `flag_o` at the next edge. A write with `wr_bit_i`=0 leaves the flag unchanged.
- R6: If a detected edge and a clearing write occur in the same cycle, `flag_o` is 1 afterwards.
- R7: With `auto_wake_i`=1, a detected edge drives `wake_req_o` high for exactly one cycle, in the same cycle that `flag_o` rises.
- R8: With `auto_wake_i`=0, a detected edge sets the flag but leaves `wake_req_o` at 0.
- R9: `irq_o` is registered. It equals the new flag value ANDed with `irq_en_i` as sampled at the same edge, so `irq_o` is never 1 while `flag_o` is 0.
- R10: Once set, `flag_o` stays 1 until it is cleared by a write, including after `sleep_i` drops to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | CAN receive line, asynchronous (1 = recessive, 0 = dominant) |
| sleep_i | input | 1 | Controller is in sleep mode |
| auto_wake_i | input | 1 | Enables the wake request on detected activity |
| irq_en_i | input | 1 | Interrupt enable for the activity flag |
| wr_en_i | input | 1 | Register write strobe for the flag position |
| wr_bit_i | input | 1 | Data bit written at the flag position (1 clears) |
| flag_o | output | 1 | Sticky bus-activity flag |
| irq_o | output | 1 | Interrupt request |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
The properties assume `rx_i` rests at recessive while reset is asserted. The edge history starts at the recessive level, so a line held dominant through reset release would count as a genuine transition. The bench holds `rx_i` at 1 during reset and changes the line, the mode bits and the write port only at falling clock edges, away from the sampling edge. Random phases then toggle the line with a bias, so that edges arrive both in and out of sleep and overlap with clearing writes.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;
  typedef enum logic {
    LVL_DOMINANT  = 1'b0,
    LVL_RECESSIVE = 1'b1
  } can_level_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync
  import can_wake_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= LVL_RECESSIVE;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= LVL_RECESSIVE;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/can_fall_detect.sv
module can_fall_detect
  import can_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= LVL_RECESSIVE;
    else     prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/can_act_flag.sv
module can_act_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d,
  output logic flag_q
);
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/can_sleep_wake.sv
module can_sleep_wake
  import can_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  input  logic sleep_i,
  input  logic auto_wake_i,
  input  logic irq_en_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_req_o
);
  logic rx_s;
  logic fall;
  logic act_evt;
  logic clr_req;
  logic flag_nxt;
  logic irq_q;
  logic wake_q;

  can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_i),
    .dout (rx_s)
  );

  can_fall_detect u_fall (
    .clk     (clk),
    .rst     (rst),
    .level_i (rx_s),
    .fall_o  (fall)
  );

  assign act_evt = fall & sleep_i;
  assign clr_req = wr_en_i & wr_bit_i;

  can_act_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (act_evt),
    .clr_i  (clr_req),
    .flag_d (flag_nxt),
    .flag_q (flag_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= flag_nxt & irq_en_i;
      wake_q <= act_evt & auto_wake_i;
    end
  end

  assign irq_o      = irq_q;
  assign wake_req_o = wake_q;

  // R4
  awake_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !flag_o) |=> !flag_o);
  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |=> !wake_req_o);
  // R7
  wake_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> flag_o);
  // R8
  no_auto_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_wake_i |=> !wake_req_o);
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
endmodule

// File: tb/tb_can_sleep_wake.sv
module tb_can_sleep_wake;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_i = 1'b1;
  logic sleep_i = 1'b0;
  logic auto_wake_i = 1'b0;
  logic irq_en_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic wr_bit_i = 1'b0;
  logic flag_o, irq_o, wake_req_o;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // reference model state
  logic m_s1, m_s2, m_prev, m_flag, m_irq, m_wake;

  can_sleep_wake dut (
    .clk(clk), .rst(rst), .rx_i(rx_i), .sleep_i(sleep_i),
    .auto_wake_i(auto_wake_i), .irq_en_i(irq_en_i),
    .wr_en_i(wr_en_i), .wr_bit_i(wr_bit_i),
    .flag_o(flag_o), .irq_o(irq_o), .wake_req_o(wake_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic next_flag(logic cur, logic set_e, logic clr_e);
    if (set_e) return 1'b1;
    if (clr_e) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1;
      m_flag = 1'b0; m_irq = 1'b0; m_wake = 1'b0;
    end else begin
      logic ev;
      ev = m_prev & ~m_s2 & sleep_i;
      m_flag = next_flag(m_flag, ev, wr_en_i & wr_bit_i);
      m_irq  = m_flag & irq_en_i;
      m_wake = ev & auto_wake_i;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_i;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R1", "flag_o vs model", flag_o, m_flag);
      check("R7", "wake_req_o vs model", wake_req_o, m_wake);
      check("R9", "irq_o vs model", irq_o, m_irq);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd24680));
    step(3);
    rst = 1'b0;
    check("R2", "flag after reset", flag_o, 1'b0);
    check("R2", "irq after reset", irq_o, 1'b0);
    check("R2", "wake after reset", wake_req_o, 1'b0);
    cmp_on = 1'b1;

    // edge in sleep with auto-wake
    sleep_i = 1; auto_wake_i = 1; irq_en_i = 1; rx_i = 0;
    step(3);
    check("R1", "flag set by falling edge", flag_o, 1'b1);
    check("R7", "wake pulse rises with flag", wake_req_o, 1'b1);
    check("R9", "irq with enable", irq_o, 1'b1);
    step(1);
    check("R7", "wake pulse one cycle", wake_req_o, 1'b0);

    // rising edge then clear
    rx_i = 1; step(4);
    wr_en_i = 1; wr_bit_i = 1; step(1); wr_en_i = 0; wr_bit_i = 0;
    check("R5", "write one clears", flag_o, 1'b0);
    step(3);
    check("R3", "rising edge no set", flag_o, 1'b0);

    // write zero ignored
    rx_i = 0; step(3);
    check("R1", "flag set again", flag_o, 1'b1);
    rx_i = 1; wr_en_i = 1; wr_bit_i = 0; step(1); wr_en_i = 0;
    check("R5", "write zero ignored", flag_o, 1'b1);

    // sticky after leaving sleep
    sleep_i = 0; step(2);
    check("R10", "flag sticky out of sleep", flag_o, 1'b1);
    wr_en_i = 1; wr_bit_i = 1; step(1); wr_en_i = 0; wr_bit_i = 0;
    check("R5", "cleared", flag_o, 1'b0);
    rx_i = 0; step(4);
    check("R4", "edge while awake ignored", flag_o, 1'b0);
    rx_i = 1; step(3);

    // set and clear in the same cycle, auto-wake off
    sleep_i = 1; auto_wake_i = 0; rx_i = 0;
    step(2);
    wr_en_i = 1; wr_bit_i = 1; step(1); wr_en_i = 0; wr_bit_i = 0;
    check("R6", "set wins over clear", flag_o, 1'b1);
    check("R8", "no wake without auto", wake_req_o, 1'b0);
    irq_en_i = 0; step(1);
    check("R9", "irq masked", irq_o, 1'b0);
    rx_i = 1; step(3);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 4) == 0) rx_i = ~rx_i;
      if (($urandom % 32) == 0) sleep_i = ~sleep_i;
      auto_wake_i = ($urandom % 2) == 0;
      irq_en_i = ($urandom % 4) != 0;
      wr_en_i = ($urandom % 8) == 0;
      wr_bit_i = ($urandom % 2) == 0;
      step(1);
    end
    wr_en_i = 0;
    step(2);
    done = 1'b1;
    finish_run();
  end
endmodule